// File: doc/BRIEF.md
# Two-way hashed-tag branch target buffer

This block predicts where a control-flow instruction will go, using only the fetch address. The fetch stage presents a PC on the lookup port. One cycle later the block answers with a hit flag and the predicted target. Once a branch resolves, the pipeline reports its PC, its real target and whether it was taken on the update port. The block uses that report to insert, refresh or drop an entry.

Entries sit in a two-way set-associative array. Every piece of storage is a synchronous-read memory with one write port and one read port, so it can map onto block RAM. The set index comes from the low PC bits above the instruction alignment. The stored tag is a short XOR-fold of the PC bits above the index, not those bits themselves. Tag and valid bits are held twice: one copy is read by the lookup port and the other by the update port, and both are written together. A one-bit LRU flag per set picks the victim way.

The update path takes two cycles. The first cycle reads the update-side tag copy. The second cycle compares tags and writes. After reset, a sweep walks every set and clears both ways. While the sweep runs, lookups miss and updates are dropped.

Top module: `btb_two_way`

## Requirements
- R1: `lk_hit` and `lk_target` belong to the lookup presented in the previous cycle. In a cycle that does not follow a lookup request, `lk_hit` is 0.
- R2: After a taken update of PC P with target T, a lookup of P presented two or more cycles later returns hit=1 and target T.
- R3: The set index is PC bits [10:2]. The tag is the XOR of PC bits [26:11] with PC bits [31:27] zero-extended to 16 bits. Two PCs with the same index and the same folded tag alias: a lookup of one returns the entry of the other. PCs with the same upper bits but different indices do not alias.
- R4: Two PCs with the same index and different tags are held at the same time, one in each way, and both hit.
- R5: A taken update whose tag is absent from its set writes the way named by the set's LRU bit. A lookup hit or a write to a way makes the other way the LRU way. After reset every LRU bit names way 0.
- R6: A taken update whose tag is already present in a way overwrites that way's target in place. No second copy is created, and the other way keeps its contents.
- R7: A not-taken update removes the way whose tag matches. The other way of the set is unaffected. A not-taken update with no matching tag changes nothing.
- R8: After reset is released, a sweep clears all 512 sets. During the sweep, every lookup misses and every update is ignored. After the sweep, every lookup misses until an entry is inserted.
- R9: A lookup presented in the cycle after an update to the same set returns the contents from before that update. A lookup presented one cycle later sees the update.
- R10: Two updates of the same PC in back-to-back cycles act in order: the second one sees the entry written by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Lookup of the previous cycle found a valid matching entry |
| lk_target | output | 32 | Predicted target when `lk_hit` is 1, zero otherwise |
| up_valid | input | 1 | Resolved branch report this cycle |
| up_pc | input | 32 | PC of the resolved branch |
| up_target | input | 32 | Resolved target address |
| up_taken | input | 1 | 1 if the branch was taken, 0 if not taken |

## Verification
The assertions assume that `lk_pc`, `up_pc`, `up_target` and `up_taken` carry known values whenever their valid strobe is high. They also assume that reset is held low for at least one full clock edge, so the reset synchronizer and the sweep start from a clean state. The bench drives every input at the falling clock edge from fully defined values. It keeps both valid strobes at 0 while reset is asserted, and it holds reset low for several cycles every time it is applied. As a result, the tag compares and LRU writes the assertions watch never see unknown data.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // What the second update stage does to the addressed set.
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_INSERT  = 2'd1,
    UPD_REFRESH = 2'd2,
    UPD_EVICT   = 2'd3
  } upd_kind_e;

endpackage

// File: rtl/btb_sram.sv
// Single write port, single synchronous read port, read-first on collision.
module btb_sram #(
  parameter int unsigned WIDTH = 17,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/btb_tag_fold.sv
// XOR-folds the upper PC bits down to the tag width.
module btb_tag_fold #(
  parameter int unsigned IN_W  = 21,
  parameter int unsigned TAG_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [TAG_W-1:0] tag
);

  localparam int unsigned CHUNKS = (IN_W + TAG_W - 1) / TAG_W;
  localparam int unsigned PAD_W  = CHUNKS * TAG_W;

  logic [PAD_W-1:0] padded;

  assign padded = PAD_W'(din);

  always_comb begin
    tag = '0;
    for (int c = 0; c < int'(CHUNKS); c++) begin
      tag = tag ^ padded[c*TAG_W +: TAG_W];
    end
  end

endmodule

// File: rtl/btb_clear.sv
// Post-reset sweep: one set address per cycle, busy until the last one.
module btb_clear #(
  parameter int unsigned SETS = 512,
  localparam int unsigned AW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(SETS - 1);

  logic          busy_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    busy_d = busy;
    addr_d = addr;
    if (busy) begin
      addr_d = addr + 1'b1;
      if (addr == LAST) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      addr <= '0;
    end else begin
      busy <= busy_d;
      addr <= addr_d;
    end
  end

endmodule

// File: rtl/btb_lru.sv
// One replacement bit per set; the insert port wins over the lookup port.
module btb_lru #(
  parameter int unsigned SETS = 512,
  localparam int unsigned AW  = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_we,
  input  logic [AW-1:0]   hit_set,
  input  logic            hit_way,
  input  logic            ins_we,
  input  logic [AW-1:0]   ins_set,
  input  logic            ins_way,
  input  logic [AW-1:0]   rd_set,
  output logic            rd_way,
  output logic [SETS-1:0] bits
);

  logic [SETS-1:0] bits_d;

  always_comb begin
    bits_d = bits;
    if (hit_we) begin
      bits_d[hit_set] = ~hit_way;
    end
    if (ins_we) begin
      bits_d[ins_set] = ~ins_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else begin
      bits <= bits_d;
    end
  end

  assign rd_way = bits[rd_set];

endmodule

// File: rtl/btb_two_way.sv
module btb_two_way
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ALIGN_W = 2,
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned TGT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_hit,
  output logic [TGT_W-1:0] lk_target,
  input  logic             up_valid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [TGT_W-1:0] up_target,
  input  logic             up_taken
);

  localparam int unsigned WAYS  = 2;
  localparam int unsigned SETS  = ENTRIES / WAYS;
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned UP_W  = PC_W - ALIGN_W - IDX_W;
  localparam int unsigned ENT_W = TAG_W + 1;

  // Reset: asynchronous assert, synchronous release.
  logic rst_s1, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  // Sweep after reset.
  logic             busy;
  logic [IDX_W-1:0] clr_addr;

  btb_clear #(.SETS(SETS)) u_clear (
    .clk   (clk),
    .rst_n (rst_q),
    .busy  (busy),
    .addr  (clr_addr)
  );

  // Address split and tag hashing for both ports.
  logic [IDX_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;

  assign lk_set = lk_pc[ALIGN_W +: IDX_W];
  assign up_set = up_pc[ALIGN_W +: IDX_W];

  btb_tag_fold #(.IN_W(UP_W), .TAG_W(TAG_W)) u_fold_lk (
    .din (lk_pc[PC_W-1 -: UP_W]),
    .tag (lk_tag)
  );

  btb_tag_fold #(.IN_W(UP_W), .TAG_W(TAG_W)) u_fold_up (
    .din (up_pc[PC_W-1 -: UP_W]),
    .tag (up_tag)
  );

  logic lk_fire, up_fire;
  assign lk_fire = lk_valid & ~busy;
  assign up_fire = up_valid & ~busy;

  // Lookup stage 1 registers.
  logic             l1_v;
  logic [IDX_W-1:0] l1_set;
  logic [TAG_W-1:0] l1_tag;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      l1_v   <= 1'b0;
      l1_set <= '0;
      l1_tag <= '0;
    end else begin
      l1_v <= lk_fire;
      if (lk_fire) begin
        l1_set <= lk_set;
        l1_tag <= lk_tag;
      end
    end
  end

  // Update stage 1 registers.
  logic             u1_v;
  logic [IDX_W-1:0] u1_set;
  logic [TAG_W-1:0] u1_tag;
  logic [TGT_W-1:0] u1_tgt;
  logic             u1_taken;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      u1_v     <= 1'b0;
      u1_set   <= '0;
      u1_tag   <= '0;
      u1_tgt   <= '0;
      u1_taken <= 1'b0;
    end else begin
      u1_v <= up_fire;
      if (up_fire) begin
        u1_set   <= up_set;
        u1_tag   <= up_tag;
        u1_tgt   <= up_target;
        u1_taken <= up_taken;
      end
    end
  end

  // Storage per way.
  logic [WAYS-1:0][ENT_W-1:0] rd_a, rd_b;
  logic [WAYS-1:0][TGT_W-1:0] rd_t;
  logic [WAYS-1:0]            upd_dir_we, upd_tgt_we, dir_we;
  logic [IDX_W-1:0]           dir_waddr;
  logic [ENT_W-1:0]           dir_wdata, upd_ent;

  assign dir_waddr = busy ? clr_addr : u1_set;
  assign dir_wdata = busy ? '0 : upd_ent;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign dir_we[w] = busy | upd_dir_we[w];

    btb_sram #(.WIDTH(ENT_W), .DEPTH(SETS)) u_dir_lk (
      .clk   (clk),
      .we    (dir_we[w]),
      .waddr (dir_waddr),
      .wdata (dir_wdata),
      .re    (lk_fire),
      .raddr (lk_set),
      .rdata (rd_a[w])
    );

    btb_sram #(.WIDTH(ENT_W), .DEPTH(SETS)) u_dir_up (
      .clk   (clk),
      .we    (dir_we[w]),
      .waddr (dir_waddr),
      .wdata (dir_wdata),
      .re    (up_fire),
      .raddr (up_set),
      .rdata (rd_b[w])
    );

    btb_sram #(.WIDTH(TGT_W), .DEPTH(SETS)) u_tgt (
      .clk   (clk),
      .we    (upd_tgt_we[w] & ~busy),
      .waddr (u1_set),
      .wdata (u1_tgt),
      .re    (lk_fire),
      .raddr (lk_set),
      .rdata (rd_t[w])
    );
  end

  // Lookup compare.
  logic [WAYS-1:0] lk_way_hit;
  logic            hit_way;

  always_comb begin
    for (int w = 0; w < int'(WAYS); w++) begin
      lk_way_hit[w] = l1_v & rd_a[w][TAG_W] & (rd_a[w][TAG_W-1:0] == l1_tag);
    end
    hit_way = ~lk_way_hit[0];
    if (lk_way_hit[0]) begin
      lk_target = rd_t[0];
    end else if (lk_way_hit[1]) begin
      lk_target = rd_t[1];
    end else begin
      lk_target = '0;
    end
  end

  assign lk_hit = |lk_way_hit;

  // Forwarding of the previous update write (its tag read was stale).
  logic             fwd_v;
  logic [IDX_W-1:0] fwd_set;
  logic             fwd_way;
  logic [ENT_W-1:0] fwd_ent;

  // Update decision.
  logic [WAYS-1:0][ENT_W-1:0] ent_eff;
  logic [WAYS-1:0]            um;
  logic                       lru_way, sel_way, ins_we;
  upd_kind_e                  u_kind;

  always_comb begin
    for (int w = 0; w < int'(WAYS); w++) begin
      if (fwd_v && (fwd_set == u1_set) && (int'(fwd_way) == w)) begin
        ent_eff[w] = fwd_ent;
      end else begin
        ent_eff[w] = rd_b[w];
      end
      um[w] = ent_eff[w][TAG_W] & (ent_eff[w][TAG_W-1:0] == u1_tag);
    end

    if (!u1_v) begin
      u_kind = UPD_NONE;
    end else if (u1_taken) begin
      u_kind = (|um) ? UPD_REFRESH : UPD_INSERT;
    end else begin
      u_kind = (|um) ? UPD_EVICT : UPD_NONE;
    end

    sel_way = (u_kind == UPD_INSERT) ? lru_way : ~um[0];
    upd_ent = {(u_kind != UPD_EVICT), u1_tag};
    ins_we  = (u_kind == UPD_INSERT) || (u_kind == UPD_REFRESH);

    for (int w = 0; w < int'(WAYS); w++) begin
      upd_dir_we[w] = (u_kind != UPD_NONE) && (int'(sel_way) == w);
      upd_tgt_we[w] = ins_we && (int'(sel_way) == w);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fwd_v   <= 1'b0;
      fwd_set <= '0;
      fwd_way <= 1'b0;
      fwd_ent <= '0;
    end else begin
      fwd_v <= (u_kind != UPD_NONE);
      if (u_kind != UPD_NONE) begin
        fwd_set <= u1_set;
        fwd_way <= sel_way;
        fwd_ent <= upd_ent;
      end
    end
  end

  // Replacement state.
  logic [SETS-1:0] lru_bits;

  btb_lru #(.SETS(SETS)) u_lru (
    .clk     (clk),
    .rst_n   (rst_q),
    .hit_we  (lk_hit),
    .hit_set (l1_set),
    .hit_way (hit_way),
    .ins_we  (ins_we),
    .ins_set (u1_set),
    .ins_way (sel_way),
    .rd_set  (u1_set),
    .rd_way  (lru_way),
    .bits    (lru_bits)
  );

  logic unused_sink;
  assign unused_sink = ^{lk_pc[ALIGN_W-1:0], up_pc[ALIGN_W-1:0], lru_bits};

endmodule

// File: rtl/btb_two_way_chk.sv
module btb_two_way_chk #(
  parameter int unsigned SETS  = 512,
  parameter int unsigned IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic             busy,
  input logic             u1_v,
  input logic [1:0]       lk_way_hit,
  input logic [1:0]       upd_dir_we,
  input logic             ins_we,
  input logic [IDX_W-1:0] ins_set,
  input logic             ins_way,
  input logic [SETS-1:0]  lru_bits
);

  AST_HIT_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_hit); // R1

  AST_CLEAR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lk_valid) |=> !lk_hit); // R8

  AST_CLEAR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !u1_v); // R8

  AST_SINGLE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_way_hit)); // R6

  AST_SINGLE_WAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_dir_we)); // R7

  AST_LRU_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_we |=> (lru_bits[$past(ins_set)] == ~$past(ins_way))); // R5

endmodule

bind btb_two_way btb_two_way_chk #(.SETS(SETS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .lk_valid   (lk_valid),
  .lk_hit     (lk_hit),
  .busy       (busy),
  .u1_v       (u1_v),
  .lk_way_hit (lk_way_hit),
  .upd_dir_we (upd_dir_we),
  .ins_we     (ins_we),
  .ins_set    (u1_set),
  .ins_way    (sel_way),
  .lru_bits   (lru_bits)
);

// File: tb/test_btb_two_way.sv
module test_btb_two_way;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_pc;
  logic        lk_hit;
  logic [31:0] lk_target;
  logic        up_valid;
  logic [31:0] up_pc;
  logic [31:0] up_target;
  logic        up_taken;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  btb_two_way i_btb_two_way (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_pc     (lk_pc),
    .lk_hit    (lk_hit),
    .lk_target (lk_target),
    .up_valid  (up_valid),
    .up_pc     (up_pc),
    .up_target (up_target),
    .up_taken  (up_taken)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] pc_of(input logic [20:0] up, input logic [8:0] ix);
    return {up, ix, 2'b00};
  endfunction

  // op: 1 taken update, 2 not-taken update, 3 lookup
  typedef struct packed {
    logic [1:0]  op;
    logic [20:0] up;
    logic [8:0]  ix;
    logic [31:0] val;
    logic        hit;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 21'd1, 9'd5, 32'h0000_1000, 1'b0},
    '{2'd3, 21'd1, 9'd5, 32'h0000_1000, 1'b1},  // R2
    '{2'd3, 21'd2, 9'd5, 32'h0000_0000, 1'b0},  // R2 miss
    '{2'd1, 21'd2, 9'd5, 32'h0000_2000, 1'b0},
    '{2'd3, 21'd1, 9'd5, 32'h0000_1000, 1'b1},  // R4
    '{2'd3, 21'd2, 9'd5, 32'h0000_2000, 1'b1},  // R4
    '{2'd1, 21'd3, 9'd5, 32'h0000_3000, 1'b0},
    '{2'd3, 21'd1, 9'd5, 32'h0000_0000, 1'b0},  // R5 victim
    '{2'd3, 21'd2, 9'd5, 32'h0000_2000, 1'b1},  // R5
    '{2'd3, 21'd3, 9'd5, 32'h0000_3000, 1'b1},  // R5
    '{2'd2, 21'd3, 9'd5, 32'h0000_0000, 1'b0},
    '{2'd3, 21'd3, 9'd5, 32'h0000_0000, 1'b0},  // R7
    '{2'd3, 21'd2, 9'd5, 32'h0000_2000, 1'b1},  // R7
    '{2'd2, 21'd7, 9'd5, 32'h0000_0000, 1'b0},
    '{2'd3, 21'd2, 9'd5, 32'h0000_2000, 1'b1},  // R7 no match
    '{2'd1, 21'd2, 9'd5, 32'h0000_2222, 1'b0},
    '{2'd3, 21'd2, 9'd5, 32'h0000_2222, 1'b1},  // R6
    '{2'd1, 21'd4, 9'd5, 32'h0000_4000, 1'b0},
    '{2'd3, 21'd2, 9'd5, 32'h0000_2222, 1'b1},  // R6 in place
    '{2'd3, 21'd4, 9'd5, 32'h0000_4000, 1'b1},  // R6
    '{2'd1, 21'd0, 9'd9, 32'h0000_5000, 1'b0},
    '{2'd3, 21'h10001, 9'd9, 32'h0000_5000, 1'b1}, // R3 alias
    '{2'd3, 21'd0, 9'd10, 32'h0000_0000, 1'b0}     // R3 other index
  };

  task automatic chk(input string req, input logic eh, input logic [31:0] et);
    n_chk++;
    if (lk_hit !== eh || (eh && lk_target !== et)) begin
      n_fail++;
      $display("FAIL %s: hit=%0b target=%h, expected hit=%0b target=%h",
               req, lk_hit, lk_target, eh, et);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input logic eh, input logic [31:0] et,
                        input string req);
    lk_valid = 1'b1;
    lk_pc    = pc;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, eh, et);
  endtask

  task automatic update(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
    up_valid  = 1'b1;
    up_pc     = pc;
    up_target = tgt;
    up_taken  = tk;
    @(negedge clk);
    up_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    lk_valid = 1'b0; lk_pc = '0;
    up_valid = 1'b0; up_pc = '0; up_target = '0; up_taken = 1'b0;
    @(negedge clk);
    do_reset();
    repeat (600) @(negedge clk);
    chk("R1 reset idle", 1'b0, 32'h0);
    lookup(pc_of(21'd1, 9'd5), 1'b0, 32'h0, "R8 empty after sweep");

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd1: update(pc_of(VEC[i].up, VEC[i].ix), VEC[i].val, 1'b1);
        2'd2: update(pc_of(VEC[i].up, VEC[i].ix), VEC[i].val, 1'b0);
        2'd3: lookup(pc_of(VEC[i].up, VEC[i].ix), VEC[i].hit, VEC[i].val,
                     $sformatf("R2-table vector %0d", i));
        default: @(negedge clk);
      endcase
    end

    // R1: no request, no hit, even with a hitting entry present.
    lookup(pc_of(21'd2, 9'd5), 1'b1, 32'h2222, "R1 request hit");
    @(negedge clk);
    chk("R1 no request", 1'b0, 32'h0);

    // R9: lookup in the cycle after an update to the same set.
    up_valid = 1'b1; up_pc = pc_of(21'd5, 9'd20); up_target = 32'h9000; up_taken = 1'b1;
    @(negedge clk);
    up_valid = 1'b0;
    lk_valid = 1'b1; lk_pc = pc_of(21'd5, 9'd20);
    @(negedge clk);
    chk("R9 pre-update view", 1'b0, 32'h0);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R9 post-update view", 1'b1, 32'h9000);

    // R10: back-to-back taken updates of one PC.
    up_valid = 1'b1; up_pc = pc_of(21'd6, 9'd30); up_target = 32'hA000; up_taken = 1'b1;
    @(negedge clk);
    up_target = 32'hB000;
    @(negedge clk);
    up_valid = 1'b0;
    repeat (2) @(negedge clk);
    lookup(pc_of(21'd6, 9'd30), 1'b1, 32'hB000, "R10 second taken wins");
    lookup(pc_of(21'd9, 9'd30), 1'b0, 32'h0, "R10 no duplicate");

    // R10: taken then not-taken, back to back, on a fresh PC.
    up_valid = 1'b1; up_pc = pc_of(21'd8, 9'd31); up_target = 32'hC000; up_taken = 1'b1;
    @(negedge clk);
    up_taken = 1'b0;
    @(negedge clk);
    up_valid = 1'b0;
    repeat (2) @(negedge clk);
    lookup(pc_of(21'd8, 9'd31), 1'b0, 32'h0, "R10 evict sees insert");

    // R8: reset sweep behaviour.
    update(pc_of(21'd1, 9'd500), 32'hD000, 1'b1);
    lookup(pc_of(21'd1, 9'd500), 1'b1, 32'hD000, "R8 before reset");
    do_reset();
    repeat (10) @(negedge clk);
    lookup(pc_of(21'd1, 9'd500), 1'b0, 32'h0, "R8 miss during sweep");
    repeat (20) @(negedge clk);
    update(pc_of(21'd1, 9'd3), 32'hE000, 1'b1);
    repeat (600) @(negedge clk);
    lookup(pc_of(21'd1, 9'd500), 1'b0, 32'h0, "R8 cleared by sweep");
    lookup(pc_of(21'd1, 9'd3), 1'b0, 32'h0, "R8 update ignored during sweep");
    lookup(pc_of(21'd2, 9'd5), 1'b0, 32'h0, "R8 old entry gone");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule